// File: doc/BRIEF.md
# SPI Command Register Interface

This block is an SPI slave. It turns fixed 16-bit command words from a host into accesses on an internal register file. It runs entirely on a fast system clock. The SPI clock, the active-low select and the MOSI line are treated as ordinary asynchronous inputs: they are synchronized, and their edges are detected in the system clock domain. Each complete word names one register with a 6-bit selector. The word can write an 8-bit value into that register, or it can read the register as a 16-bit value.

The result of a read does not come back in the same word. It is latched into a holding register and shifted out on MISO during the next word, while that word's own command is shifted in. A host can therefore stream reads back to back with one word of latency. This suits draining the sample FIFO that sits behind the highest address. The register file holds an identification constant, a set of 8-bit control registers, and a parameterized number of GPIO ports. Each GPIO port has an input register, an output register and a direction register.

Top module: `spi_regif`

## Requirements
- R1: SPI mode 0, MSB first. MOSI is sampled on SCLK rising edges and MISO changes only after SCLK falling edges. The first MISO bit is valid as soon as select is low.
- R2: Command word layout: bit 15 = read, bit 14 = write, bits 13..8 = register selector, bits 7..0 = write value.
- R3: A write to a control register (selectors 1 to NUM_CTRL) stores the value field, which appears on `ctrl_o[8*(sel-1) +: 8]`.
- R4: A read-only word latches the selected register, zero-extended to 16 bits, and that value is shifted out during the next complete word. Any other complete word (write, both bits or neither bit) loads 0 for the next word.
- R5: A word with both the read and write bits set performs only the write. A word with neither bit set changes no register.
- R6: Selector 0 reads the constant ID_VALUE (default 16'h5A17). Writes to it are ignored.
- R7: Selector 63 reads the head of the external FIFO and pulses `fifo_pop_o` for exactly one clock per read. Writes to selector 63 cause no pop.
- R8: GPIO port p uses selectors 8+4p (input, the pin levels after two-flop synchronization), 9+4p (output) and 10+4p (direction). `gpio_oe_o` equals the direction register, and a pin's `gpio_out_o` bit equals its output bit only where its direction bit is 1, otherwise 0.
- R9: A select-high period that does not enclose exactly 16 SCLK rising edges is discarded: no write happens, and the holding register keeps its value.
- R10: After reset all control, GPIO output and direction registers are 0, the holding register is 0 and MISO is low.
- R11: Unmapped selectors read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SPI clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock from the host |
| cs_ni | input | 1 | Active-low SPI select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| fifo_data_i | input | 16 | Head entry of the external read FIFO |
| fifo_pop_o | output | 1 | One-clock pop request to the FIFO |
| ctrl_o | output | NUM_CTRL*8 | Control register contents |
| gpio_in_i | input | NUM_GPIO*GPIO_W | GPIO pin levels |
| gpio_out_o | output | NUM_GPIO*GPIO_W | GPIO output values, masked by direction |
| gpio_oe_o | output | NUM_GPIO*GPIO_W | GPIO output enables |

## Verification
The bench goes after the one-word read latency. A design that returned the result in the same word, or that kept a stale read after a write, would show shifted or repeated values during streamed reads of the control registers and the FIFO. Words with both command bits set, with neither bit set, and with 9 or 20 clocks are sent between reads. These catch a design that also reads on a combined word, or that clears or overwrites the holding register on a discarded frame. The GPIO ports are driven with partial direction masks to expose an output that ignores direction. Writes to read-only and unmapped selectors check that nothing leaks into a neighbouring register. A pop count compared against the number of FIFO reads catches double pops, and pops caused by writes.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int WORD_W      = 16;
  localparam int ADDR_W      = 6;
  localparam int VAL_W       = 8;
  localparam int CTRL_BASE   = 1;
  localparam int GPIO_BASE   = 8;
  localparam int GPIO_STRIDE = 4;
  localparam logic [ADDR_W-1:0] ID_ADDR   = '0;
  localparam logic [ADDR_W-1:0] FIFO_ADDR = '1;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [ADDR_W-1:0] sel;
    logic [VAL_W-1:0]  val;
  } cmd_t;
endpackage

// File: rtl/spi_regif_link.sv
module spi_regif_link #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

  logic [SYNC_STAGES-1:0] sclk_ff, cs_ff, mosi_ff;
  logic sclk_prev, cs_prev;
  logic sclk_s, cs_s, mosi_s, sclk_rise, sclk_fall, cs_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_ff   <= '0;
      cs_ff     <= '1;
      mosi_ff   <= '0;
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
    end else begin
      sclk_ff   <= {sclk_ff[SYNC_STAGES-2:0], sclk_i};
      cs_ff     <= {cs_ff[SYNC_STAGES-2:0], cs_ni};
      mosi_ff   <= {mosi_ff[SYNC_STAGES-2:0], mosi_i};
      sclk_prev <= sclk_s;
      cs_prev   <= cs_s;
    end
  end

  assign sclk_s    = sclk_ff[SYNC_STAGES-1];
  assign cs_s      = cs_ff[SYNC_STAGES-1];
  assign mosi_s    = mosi_ff[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;
  assign cs_rise   = cs_s & ~cs_prev;

  // select high: reload reply, clear count; select low: shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
      tx_sh   <= tx_word_i;
    end else begin
      if (sclk_rise) begin
        rx_sh   <= {rx_sh[WORD_W-2:0], mosi_s};
        bit_cnt <= (bit_cnt == CNT_MAX) ? bit_cnt : bit_cnt + 1'b1;
      end
      if (sclk_fall) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

  assign word_valid_o = cs_rise && (bit_cnt == CNT_WORD);
  assign word_o       = rx_sh;
  assign miso_o       = tx_sh[WORD_W-1];

  // R1: MISO only moves after a falling SCLK while selected
  a_r1_miso_mode0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cs_s) && !$past(sclk_fall)) |-> $stable(miso_o));
  // R9: bit count held at zero while deselected
  a_r9_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_s) && cs_s) |-> (bit_cnt == '0));
endmodule

// File: rtl/spi_regif_bank.sv
module spi_regif_bank
  import spi_regif_pkg::*;
#(
  parameter int          NUM_CTRL = 4,
  parameter int          NUM_GPIO = 2,
  parameter int          GPIO_W   = 6,
  parameter logic [15:0] ID_VALUE = 16'h5A17
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          sel_i,
  input  logic [VAL_W-1:0]           wr_data_i,
  input  logic [WORD_W-1:0]          fifo_data_i,
  input  logic [NUM_GPIO*GPIO_W-1:0] gpio_in_i,
  output logic [WORD_W-1:0]          rd_data_o,
  output logic [NUM_CTRL*VAL_W-1:0]  ctrl_o,
  output logic [NUM_GPIO*GPIO_W-1:0] gpio_out_o,
  output logic [NUM_GPIO*GPIO_W-1:0] gpio_oe_o
);
  logic [VAL_W-1:0]  ctrl_rd [NUM_CTRL];
  logic [GPIO_W-1:0] gin_rd  [NUM_GPIO];
  logic [GPIO_W-1:0] gout_rd [NUM_GPIO];
  logic [GPIO_W-1:0] gdir_rd [NUM_GPIO];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_BASE + i);
    logic [VAL_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && sel_i == SEL) q <= wr_data_i;
    end
    assign ctrl_o[i*VAL_W +: VAL_W] = q;
    assign ctrl_rd[i] = q;

    a_r3_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && sel_i == SEL) |=> (ctrl_o[i*VAL_W +: VAL_W] == $past(wr_data_i)));
  end

  for (genvar p = 0; p < NUM_GPIO; p++) begin : g_gpio
    localparam logic [ADDR_W-1:0] SEL_OUT = ADDR_W'(GPIO_BASE + GPIO_STRIDE*p + 1);
    localparam logic [ADDR_W-1:0] SEL_DIR = ADDR_W'(GPIO_BASE + GPIO_STRIDE*p + 2);
    logic [GPIO_W-1:0] out_q, dir_q, sync1_q, sync2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q   <= '0;
        dir_q   <= '0;
        sync1_q <= '0;
        sync2_q <= '0;
      end else begin
        sync1_q <= gpio_in_i[p*GPIO_W +: GPIO_W];
        sync2_q <= sync1_q;
        if (wr_en_i && sel_i == SEL_OUT) out_q <= wr_data_i[GPIO_W-1:0];
        if (wr_en_i && sel_i == SEL_DIR) dir_q <= wr_data_i[GPIO_W-1:0];
      end
    end
    assign gpio_out_o[p*GPIO_W +: GPIO_W] = out_q & dir_q;
    assign gpio_oe_o[p*GPIO_W +: GPIO_W]  = dir_q;
    assign gin_rd[p]  = sync2_q;
    assign gout_rd[p] = out_q;
    assign gdir_rd[p] = dir_q;

    a_r8_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && sel_i == SEL_DIR) |=> (gpio_oe_o[p*GPIO_W +: GPIO_W] == $past(wr_data_i[GPIO_W-1:0])));
  end

  always_comb begin
    rd_data_o = '0;
    if (sel_i == ID_ADDR)   rd_data_o = ID_VALUE;
    if (sel_i == FIFO_ADDR) rd_data_o = fifo_data_i;
    for (int i = 0; i < NUM_CTRL; i++)
      if (sel_i == ADDR_W'(CTRL_BASE + i)) rd_data_o = {{(WORD_W-VAL_W){1'b0}}, ctrl_rd[i]};
    for (int p = 0; p < NUM_GPIO; p++) begin
      if (sel_i == ADDR_W'(GPIO_BASE + GPIO_STRIDE*p))     rd_data_o = WORD_W'(gin_rd[p]);
      if (sel_i == ADDR_W'(GPIO_BASE + GPIO_STRIDE*p + 1)) rd_data_o = WORD_W'(gout_rd[p]);
      if (sel_i == ADDR_W'(GPIO_BASE + GPIO_STRIDE*p + 2)) rd_data_o = WORD_W'(gdir_rd[p]);
    end
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int          NUM_CTRL = 4,
  parameter int          NUM_GPIO = 2,
  parameter int          GPIO_W   = 6,
  parameter logic [15:0] ID_VALUE = 16'h5A17
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       mosi_i,
  output logic                       miso_o,
  input  logic [15:0]                fifo_data_i,
  output logic                       fifo_pop_o,
  output logic [NUM_CTRL*8-1:0]      ctrl_o,
  input  logic [NUM_GPIO*GPIO_W-1:0] gpio_in_i,
  output logic [NUM_GPIO*GPIO_W-1:0] gpio_out_o,
  output logic [NUM_GPIO*GPIO_W-1:0] gpio_oe_o
);
  logic              word_valid;
  logic [WORD_W-1:0] word, rd_data, hold_q;
  logic              wr_en, rd_en, pop_q;
  cmd_t              cmd;

  spi_regif_link #(.WORD_W(WORD_W)) u_link (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_i),
    .cs_ni        (cs_ni),
    .mosi_i       (mosi_i),
    .tx_word_i    (hold_q),
    .miso_o       (miso_o),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  assign cmd   = cmd_t'(word);
  assign wr_en = word_valid & cmd.wr;
  assign rd_en = word_valid & cmd.rd & ~cmd.wr;  // write wins on a combined word

  spi_regif_bank #(
    .NUM_CTRL (NUM_CTRL),
    .NUM_GPIO (NUM_GPIO),
    .GPIO_W   (GPIO_W),
    .ID_VALUE (ID_VALUE)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .sel_i       (cmd.sel),
    .wr_data_i   (cmd.val),
    .fifo_data_i (fifo_data_i),
    .gpio_in_i   (gpio_in_i),
    .rd_data_o   (rd_data),
    .ctrl_o      (ctrl_o),
    .gpio_out_o  (gpio_out_o),
    .gpio_oe_o   (gpio_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pop_q  <= 1'b0;
    end else begin
      pop_q <= rd_en && (cmd.sel == FIFO_ADDR);
      if (word_valid) hold_q <= rd_en ? rd_data : '0;
    end
  end

  assign fifo_pop_o = pop_q;

  a_r5_single_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en, rd_en}));
  a_r7_pop_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o);
  a_r7_pop_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (hold_q == $past(fifo_data_i)));
endmodule

// File: tb/spi_regif_test.sv
module spi_regif_test;
  localparam int HALF = 10;
  localparam int GAP  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, fifo_pop;
  logic [15:0] fifo_head = 16'h0;
  logic [31:0] ctrl;
  logic [11:0] gin = 12'h0, gout, goe;

  always #4 clk = ~clk;

  spi_regif uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .fifo_data_i(fifo_head), .fifo_pop_o(fifo_pop),
    .ctrl_o(ctrl), .gpio_in_i(gin), .gpio_out_o(gout), .gpio_oe_o(goe)
  );

  int checks = 0, errors = 0, quiet = 0, pops = 0, exp_pops = 0;
  bit done = 0;
  logic [7:0]  m_ctrl [4];
  logic [5:0]  m_out [2], m_dir [2];
  logic [15:0] m_hold = 16'h0;
  logic [15:0] fq[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(logic [5:0] a);
    if (a == 0) return 16'h5A17;
    if (a >= 1 && a <= 4) return {8'h0, m_ctrl[a-1]};
    if (a == 8)  return {10'h0, gin[5:0]};
    if (a == 9)  return {10'h0, m_out[0]};
    if (a == 10) return {10'h0, m_dir[0]};
    if (a == 12) return {10'h0, gin[11:6]};
    if (a == 13) return {10'h0, m_out[1]};
    if (a == 14) return {10'h0, m_dir[1]};
    if (a == 63) return fq[0];
    return 16'h0;
  endfunction

  // per-clock comparison of register outputs against the model (R3, R8, R10, R11)
  always @(negedge clk) begin
    if (fifo_pop) begin
      pops++;
      void'(fq.pop_front());
      fifo_head = (fq.size() > 0) ? fq[0] : 16'h0;
    end
    if (rst_n && !done) begin
      if (quiet > 0) quiet--;
      else begin
        logic [31:0] ec;
        logic [11:0] eo, ed;
        for (int i = 0; i < 4; i++) ec[i*8 +: 8] = m_ctrl[i];
        for (int p = 0; p < 2; p++) begin
          ed[p*6 +: 6] = m_dir[p];
          eo[p*6 +: 6] = m_out[p] & m_dir[p];
        end
        if (ctrl !== ec) begin errors++; $display("FAIL R3/R11 ctrl actual=%h expected=%h", ctrl, ec); end
        if (goe !== ed)  begin errors++; $display("FAIL R8 oe actual=%h expected=%h", goe, ed); end
        if (gout !== eo) begin errors++; $display("FAIL R8 out actual=%h expected=%h", gout, eo); end
        checks++;
      end
    end
  end

  task automatic word(input logic [15:0] tx, input int nbits, input string req, input bit check_rx);
    logic [15:0] rx = 16'h0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = tx[15 - (b % 16)];
      repeat (HALF) @(negedge clk);
      rx = {rx[14:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    quiet = 12;
    if (nbits == 16) begin
      if (check_rx) chk(req, {16'h0, rx}, {16'h0, m_hold});
      if (tx[14]) begin
        if (tx[13:8] >= 1 && tx[13:8] <= 4) m_ctrl[tx[13:8]-1] = tx[7:0];
        if (tx[13:8] == 9)  m_out[0] = tx[5:0];
        if (tx[13:8] == 10) m_dir[0] = tx[5:0];
        if (tx[13:8] == 13) m_out[1] = tx[5:0];
        if (tx[13:8] == 14) m_dir[1] = tx[5:0];
      end
      if (tx[15] && !tx[14]) begin
        m_hold = model_rd(tx[13:8]);
        if (tx[13:8] == 63) exp_pops++;
      end else m_hold = 16'h0;
    end
    repeat (GAP) @(negedge clk);
  endtask

  function automatic logic [15:0] wr(int a, int v); return 16'h4000 | 16'(a << 8) | 16'(v & 8'hFF); endfunction
  function automatic logic [15:0] rd(int a); return 16'h8000 | 16'(a << 8); endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_ctrl[i] = 8'h0;
    for (int p = 0; p < 2; p++) begin m_out[p] = 6'h0; m_dir[p] = 6'h0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 miso", {31'h0, miso}, 32'h0);
    chk("R10 ctrl", ctrl, 32'h0);
    chk("R10 oe", {20'h0, goe}, 32'h0);

    // R1 R2 R3 R4 basic write then streamed reads
    word(wr(1, 8'hA5), 16, "R10 first reply", 1);
    word(rd(1), 16, "R4 after write", 1);
    word(rd(0), 16, "R4 ctrl1 readback", 1);
    word(16'h0000, 16, "R6 id value", 1);
    word(wr(2, 8'h3C), 16, "R5 noop reply", 1);
    word(wr(3, 8'hC3), 16, "R3 write", 1);
    word(wr(4, 8'h81), 16, "R3 write", 1);
    word(rd(2), 16, "R4", 1);
    word(rd(3), 16, "R4 stream ctrl2", 1);
    word(rd(4), 16, "R4 stream ctrl3", 1);
    word(rd(1), 16, "R1 R2 stream ctrl4", 1);
    // R5 both bits set: write only, next reply zero
    word(16'hC377, 16, "R4 stream ctrl1", 1);
    word(16'h0000, 16, "R5 combined word reply", 1);
    word(rd(3), 16, "R5 noop reply", 1);
    word(16'h0000, 16, "R5 combined write value", 1);

    // R8 GPIO
    word(wr(10, 8'h0F), 16, "R8", 1);
    word(wr(9, 8'h3C), 16, "R8", 1);
    word(wr(14, 8'h3F), 16, "R8", 1);
    word(wr(13, 8'h15), 16, "R8", 1);
    gin = {6'h2A, 6'h11};
    repeat (10) @(negedge clk);
    word(rd(8), 16, "R8", 1);
    word(rd(12), 16, "R8 port0 input", 1);
    word(rd(9), 16, "R8 port1 input", 1);
    word(rd(14), 16, "R8 port0 output reg", 1);
    word(wr(10, 8'h30), 16, "R8 port1 dir", 1);
    chk("R8 masked out", {20'h0, gout}, {20'h0, 6'h15, 6'h30 & 6'h3C});

    // R7 FIFO streaming
    fq.push_back(16'h1234); fq.push_back(16'hBEEF); fq.push_back(16'h0F0F); fq.push_back(16'h7777);
    fifo_head = fq[0];
    word(rd(63), 16, "R7", 1);
    word(rd(63), 16, "R7 fifo head0", 1);
    word(rd(63), 16, "R7 fifo head1", 1);
    word(wr(63, 8'hFF), 16, "R7 fifo head2", 1);
    word(16'h0000, 16, "R7 write reply", 1);
    chk("R7 pop count", pops, exp_pops);
    chk("R7 fifo head after write", {16'h0, fifo_head}, 32'h7777);

    // R9 discarded frames
    word(rd(1), 16, "R9", 1);
    word(wr(1, 8'h11), 9, "R9 short", 0);
    word(wr(2, 8'h22), 20, "R9 long", 0);
    word(16'h0000, 16, "R9 hold kept", 1);

    // R11 unmapped, R6 read-only id
    word(wr(20, 8'hFF), 16, "R11", 1);
    word(wr(0, 8'h00), 16, "R11", 1);
    word(rd(20), 16, "R11", 1);
    word(rd(5), 16, "R11 unmapped read", 1);
    word(rd(0), 16, "R11 unmapped read", 1);
    word(16'h0000, 16, "R6 id after write", 1);
    chk("R7 final pops", pops, exp_pops);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule